// File: doc/BRIEF.md
# Memory Signature Identification Reader

This controller asks an ultraviolet-erasable or one-time-programmable memory for its two identifier bytes and reports whether the fitted part is the one expected. After a start pulse it raises a flag that tells the board's high-voltage driver to put the identification level on the dedicated address line. While that flag is high it enables the memory and reads twice. The read with the lowest address bit low returns the manufacturer byte. The read with that bit high returns the device byte. It then leaves identification mode and compares both captured bytes with expected values supplied on its inputs.

The usual expected pair is manufacturer 20h and device 8Dh, but both are plain inputs. Each byte is sampled a fixed, parameterised number of cycles after the address and enables settle, which covers the memory's access time. The programming-voltage request stays inactive throughout, because identification runs with both supplies at their ordinary read level. The captured bytes and the match result stay on the outputs until the next completed run.

Top module: `sigid_reader`

## Requirements
- R1: Out of reset the identification flag is low, both active-low enables are high, done and match are low, and both captured bytes are 00h.
- R2: A start accepted in the idle state raises the identification flag at once. Chip-enable and output-enable stay high for SETUP_CYC cycles and then both go low. Neither enable is ever low while the identification flag is low.
- R3: Every address bit other than bit 0 is always 0. Bit 0 is 0 during the first read and 1 during the second read.
- R4: The programming-voltage request output is always 0.
- R5: Each byte is taken from the data bus at the clock edge that ends ACC_CYC cycles with the enables low and address bit 0 unchanged.
- R6: The manufacturer output holds the byte read with address bit 0 = 0, and the device output holds the byte read with bit 0 = 1. Both hold until the next run captures new values.
- R7: The match output is 1 after a run only if the manufacturer byte equals the expected manufacturer input and the device byte equals the expected device input. It is 0 otherwise. An accepted start clears it.
- R8: Done is a one-cycle pulse that starts SETUP_CYC + 2*ACC_CYC + 1 cycles after the clock edge that accepts start. The identification flag is already low in the cycle before done and during done.
- R9: A start that arrives while a run is in progress is ignored. It neither extends the run nor causes a second done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an identification run (accepted only when idle) |
| exp_mfr_i | input | DATA_W | Expected manufacturer byte |
| exp_dev_i | input | DATA_W | Expected device byte |
| dq_i | input | DATA_W | Memory data bus |
| id_hv_o | output | 1 | Request for the identification level on the dedicated address line |
| prog_hv_o | output | 1 | Programming-voltage request, always inactive |
| addr_o | output | ADDR_W | Memory address; only bit 0 ever toggles |
| ce_n_o | output | 1 | Chip enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| mfr_o | output | DATA_W | Captured manufacturer byte |
| dev_o | output | DATA_W | Captured device byte |
| match_o | output | 1 | Both bytes equal their expected values |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The properties assume that start_i is a clean synchronous level and that the expected-code inputs are steady from the end of the second read until done. The bench changes those inputs only at the falling edge of the clock between runs. It also pulses start in the middle of some runs. The memory model in the bench drives a valid code only after the enables and address bit 0 have been steady for long enough, and drives the complement of the code before that. A design that samples early, or with bit 0 swapped, therefore captures the wrong byte.

// File: rtl/sigid_pkg.sv
package sigid_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ENTER,
      ST_RD_MFR,
      ST_RD_DEV,
      ST_EXIT,
      ST_DONE
   } sig_state_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sigid_timer.sv
module sigid_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_q;

   assign hit = run && (cnt_q == limit - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || hit)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/sigid_byte_cap.sv
module sigid_byte_cap #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   input  logic [DATA_W-1:0] expect_v,
   output logic [DATA_W-1:0] q,
   output logic              eq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end

   assign eq = (q == expect_v);
endmodule

// File: rtl/sigid_reader.sv
module sigid_reader #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 15,
   parameter int unsigned SETUP_CYC = 2,
   parameter int unsigned ACC_CYC   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] exp_mfr_i,
   input  logic [DATA_W-1:0] exp_dev_i,
   input  logic [DATA_W-1:0] dq_i,
   output logic              id_hv_o,
   output logic              prog_hv_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              ce_n_o,
   output logic              oe_n_o,
   output logic [DATA_W-1:0] mfr_o,
   output logic [DATA_W-1:0] dev_o,
   output logic              match_o,
   output logic              done_o
);
   import sigid_pkg::*;

   localparam int unsigned MAX_CYC = max_u(SETUP_CYC, ACC_CYC);
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
   localparam int unsigned N_SLOT  = 2;

   if (ACC_CYC < 2) begin : g_bad_acc
      $error("sigid_reader: ACC_CYC must be at least 2");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("sigid_reader: SETUP_CYC must be at least 1");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("sigid_reader: ADDR_W must cover the identification line");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("sigid_reader: DATA_W must be positive");
   end

   sig_state_t state_q, state_d;
   logic       tmr_run, tmr_hit;
   logic [CNT_W-1:0] tmr_lim;
   logic       reading;
   logic       match_q;

   logic [N_SLOT-1:0] slot_ld;
   logic [N_SLOT-1:0] slot_eq;
   logic [DATA_W-1:0] slot_exp [N_SLOT];
   logic [DATA_W-1:0] slot_q   [N_SLOT];

   assign tmr_run = (state_q == ST_ENTER) || (state_q == ST_RD_MFR) || (state_q == ST_RD_DEV);
   assign tmr_lim = (state_q == ST_ENTER) ? CNT_W'(SETUP_CYC) : CNT_W'(ACC_CYC);

   sigid_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (tmr_run),
      .limit (tmr_lim),
      .hit   (tmr_hit)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start_i) state_d = ST_ENTER;
         ST_ENTER:  if (tmr_hit) state_d = ST_RD_MFR;
         ST_RD_MFR: if (tmr_hit) state_d = ST_RD_DEV;
         ST_RD_DEV: if (tmr_hit) state_d = ST_EXIT;
         ST_EXIT:   state_d = ST_DONE;
         ST_DONE:   state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   assign slot_ld[0]  = (state_q == ST_RD_MFR) && tmr_hit;
   assign slot_ld[1]  = (state_q == ST_RD_DEV) && tmr_hit;
   assign slot_exp[0] = exp_mfr_i;
   assign slot_exp[1] = exp_dev_i;

   for (genvar gi = 0; gi < N_SLOT; gi++) begin : g_slot
      sigid_byte_cap #(.DATA_W(DATA_W)) u_cap (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (slot_ld[gi]),
         .d        (dq_i),
         .expect_v (slot_exp[gi]),
         .q        (slot_q[gi]),
         .eq       (slot_eq[gi])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         match_q <= 1'b0;
      else if (state_q == ST_IDLE && start_i)
         match_q <= 1'b0;
      else if (state_q == ST_EXIT)
         match_q <= &slot_eq;
   end

   assign reading   = (state_q == ST_RD_MFR) || (state_q == ST_RD_DEV);
   assign id_hv_o   = tmr_run;
   assign prog_hv_o = 1'b0;
   assign ce_n_o    = !reading;
   assign oe_n_o    = !reading;
   assign addr_o    = {{(ADDR_W-1){1'b0}}, (state_q == ST_RD_DEV)};
   assign mfr_o     = slot_q[0];
   assign dev_o     = slot_q[1];
   assign match_o   = match_q;
   assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/sigid_reader_chk.sv
module sigid_reader_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              id_hv_o,
   input logic              ce_n_o,
   input logic              oe_n_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic [DATA_W-1:0] mfr_o,
   input logic [DATA_W-1:0] dev_o,
   input logic              match_o,
   input logic              done_o
);
   assert_enable_needs_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n_o || !oe_n_o) |-> id_hv_o);

   assert_first_read_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_n_o) |-> (addr_o[0] == 1'b0));

   assert_bytes_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !id_hv_o |=> ($stable(mfr_o) && $stable(dev_o)));

   assert_match_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_o) |-> done_o);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_id_off_before_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!id_hv_o && !$past(id_hv_o)));
endmodule

bind sigid_reader sigid_reader_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .id_hv_o (id_hv_o),
   .ce_n_o  (ce_n_o),
   .oe_n_o  (oe_n_o),
   .addr_o  (addr_o),
   .mfr_o   (mfr_o),
   .dev_o   (dev_o),
   .match_o (match_o),
   .done_o  (done_o)
);

// File: tb/test_sigid_reader.sv
module test_sigid_reader;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int AW = 15;
   localparam int SETUP = 2;
   localparam int ACC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [DW-1:0] exp_mfr = '0, exp_dev = '0;
   logic [DW-1:0] dq;
   logic id_hv, prog_hv, ce_n, oe_n, match, done;
   logic [AW-1:0] addr;
   logic [DW-1:0] mfr, dev;

   logic [DW-1:0] part_mfr = 8'h20, part_dev = 8'h8D;

   int checks = 0, fails = 0;
   int bad_addr = 0, bad_prog = 0, bad_en = 0;
   int setup_run = 0, last_setup = 0;
   int age = 0;
   logic [3:0] key_prev = 4'h0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sigid_reader #(.DATA_W(DW), .ADDR_W(AW), .SETUP_CYC(SETUP), .ACC_CYC(ACC)) i_sigid_reader (
      .clk(clk), .rst_n(rst_n), .start_i(start), .exp_mfr_i(exp_mfr), .exp_dev_i(exp_dev),
      .dq_i(dq), .id_hv_o(id_hv), .prog_hv_o(prog_hv), .addr_o(addr), .ce_n_o(ce_n),
      .oe_n_o(oe_n), .mfr_o(mfr), .dev_o(dev), .match_o(match), .done_o(done));

   // Memory model: a code is valid only after the controls have been steady long enough.
   wire [3:0] key_now = {id_hv, ce_n, oe_n, addr[0]};
   always @(posedge clk) begin
      if (key_now != key_prev) age <= 0;
      else if (age < 1000) age <= age + 1;
      key_prev <= key_now;
   end
   wire [DW-1:0] code_sel = addr[0] ? part_dev : part_mfr;
   assign dq = (id_hv && !ce_n && !oe_n && age >= ACC-2) ? code_sel : ~code_sel;

   // Continuous port monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (addr[AW-1:1] != '0) bad_addr++;
         if (prog_hv) bad_prog++;
         if ((!ce_n || !oe_n) && !id_hv) bad_en++;
         if (id_hv && ce_n) setup_run++;
         else if (id_hv && !ce_n && setup_run != 0) begin
            last_setup = setup_run;
            setup_run = 0;
         end else if (!id_hv) setup_run = 0;
      end
   end

   function automatic int exp_latency();
      return SETUP + 2*ACC + 2;
   endfunction

   function automatic logic exp_match(input logic [DW-1:0] m, d, em, ed);
      return (m == em) && (d == ed);
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic run_trial(input logic [DW-1:0] m, d, em, ed, input logic poke);
      int n;
      @(negedge clk);
      part_mfr = m; part_dev = d; exp_mfr = em; exp_dev = ed;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n = 1;
      while (!done && n < 200) begin
         start = poke && (n == 4);
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      start = 1'b0;
      check(n == exp_latency(), "R8 latency", n, exp_latency());
      check(!id_hv, "R8 id low at done", id_hv, 0);
      check(last_setup == SETUP, "R2 setup cycles", last_setup, SETUP);
      check(mfr == m, "R5/R6 mfr byte", mfr, m);
      check(dev == d, "R5/R6 dev byte", dev, d);
      check(match == exp_match(m, d, em, ed), "R7 match", match, exp_match(m, d, em, ed));
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (poke) check(!done && !id_hv, "R9 busy start ignored", {done, id_hv}, 0);
      end
      check(mfr == m && dev == d, "R6 bytes held", {mfr, dev}, {m, d});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [DW-1:0] m, d, em, ed;
      int unsigned sel;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check(!id_hv && ce_n && oe_n && !done && !match, "R1 reset controls",
            {id_hv, ce_n, oe_n, done, match}, 5'b01100);
      check(mfr == 0 && dev == 0, "R1 reset bytes", {mfr, dev}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_trial(8'h20, 8'h8D, 8'h20, 8'h8D, 1'b0);   // R7 expected part
      run_trial(8'h20, 8'h8C, 8'h20, 8'h8D, 1'b0);   // R7 device differs
      run_trial(8'h21, 8'h8D, 8'h20, 8'h8D, 1'b0);   // R7 maker differs
      run_trial(8'h20, 8'h8D, 8'h20, 8'h8D, 1'b1);   // R9 start mid-run
      run_trial(8'h00, 8'hFF, 8'h00, 8'hFF, 1'b0);   // boundary codes

      for (int t = 0; t < 25; t++) begin
         m = DW'($urandom); d = DW'($urandom);
         sel = $urandom % 3;
         em = (sel == 1) ? m ^ DW'(1 << ($urandom % DW)) : m;
         ed = (sel == 2) ? d ^ DW'(1 << ($urandom % DW)) : d;
         run_trial(m, d, em, ed, ($urandom % 4) == 0);
      end

      check(bad_addr == 0, "R3 upper address zero", bad_addr, 0);
      check(bad_prog == 0, "R4 prog request low", bad_prog, 0);
      check(bad_en == 0, "R2 enables only in id mode", bad_en, 0);
      finish_run();
   end
endmodule